// File: doc/BRIEF.md
# I2C Engine Ownership Arbiter

This block decides which of three agents may drive a single shared I2C engine: host software, an autonomous hardware requester (such as a periodic link-protection poller), and an embedded microcontroller. Software claims the engine by holding a claim level and gives it back by pulsing a release strobe while the claim is low. The other two agents each hold a plain request level. The arbiter publishes a two-bit owner code and a one-hot grant vector. It forwards a start (GO) command to the engine only from the agent that currently owns it.

Hardware can take the engine away from software when its priority input is high. A software batch that is cut short this way is started again automatically once the engine comes back to software. While hardware owns the engine, a software GO is either parked and launched when software regains the engine, or refused at once, depending on a configuration input. Releasing the engine produces a status-reset strobe in every case. It adds a soft-reset strobe for the engine only when software was the owner at that moment. The bit engine itself lies outside the block and reports the end of a batch through a done pulse.

States: IDLE (no owner), SW_HOLD (software owns, no batch running), SW_RUN (software batch running), HW_HOLD (hardware owns), MCU_LOCK (microcontroller-only lock). Transitions:
- IDLE goes to the highest-priority requester.
- SW_HOLD goes to SW_RUN on an accepted GO, to HW_HOLD on preemption, and to IDLE on release.
- SW_RUN goes to SW_HOLD on engine done, to HW_HOLD on preemption, and to IDLE on release.
- HW_HOLD and MCU_LOCK re-arbitrate when their request drops.

Top module: `i2c_owner_arb`

## Requirements
- R1: After reset the owner code is 0 (idle), the grant vector is 0, and every strobe output (go, abort, soft reset, status reset, GO reject) is low.
- R2: When several agents are waiting as arbitration happens, the fixed priority is microcontroller, then hardware, then software. Owner codes: 0 idle, 1 software, 2 hardware, 3 microcontroller. Grant bits: bit 0 software, bit 1 hardware, bit 2 microcontroller.
- R3: Raising the software claim while the engine is idle makes software the owner one cycle later. Pulsing the release strobe with the claim low, while software owns the engine, gives one cycle of both soft reset and status reset, and the owner returns to idle.
- R4: A software release while software is not the owner gives a status-reset pulse without a soft-reset pulse and leaves the owner unchanged.
- R5: While the owner is the microcontroller, a software claim is refused: the deny output is high, the owner stays 3, and a software GO produces a reject pulse and no engine GO.
- R6: A software GO while software owns an idle engine produces one engine GO pulse one cycle later. A software GO while its batch runs is rejected. After engine done, a new software GO is accepted.
- R7: With hardware priority high, a hardware request during a running software batch produces an abort pulse, and hardware becomes the owner one cycle later.
- R8: A software batch interrupted by hardware is restarted with an engine GO pulse in the cycle software regains the engine.
- R9: With hardware priority low, a hardware request never interrupts software. Hardware receives the engine only after a software release and an idle cycle.
- R10: With the no-queue input low, a software GO issued while hardware owns the engine and the software claim is high is not rejected. It produces an engine GO when software regains the engine.
- R11: With the no-queue input high, that same GO gives a reject pulse, and software regains the engine without an engine GO.
- R12: Hardware and microcontroller GO inputs reach the engine GO output only while that agent owns the engine and still requests it.
- R13: At most one grant bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_claim | input | 1 | Software ownership claim (level) |
| sw_free | input | 1 | Software release strobe, honoured while claim is low |
| sw_go | input | 1 | Software start command |
| hw_req | input | 1 | Hardware requester ownership request (level) |
| hw_go | input | 1 | Hardware requester start command |
| mcu_req | input | 1 | Microcontroller ownership request (level) |
| mcu_go | input | 1 | Microcontroller start command |
| hw_prio_high | input | 1 | Hardware may preempt software when high |
| no_queue_go | input | 1 | Reject, instead of park, a software GO during hardware ownership |
| eng_done | input | 1 | Engine finished the current batch (pulse) |
| owner | output | 2 | Owner code: 0 idle, 1 software, 2 hardware, 3 microcontroller |
| grant | output | 3 | One-hot grant: bit0 software, bit1 hardware, bit2 microcontroller |
| sw_denied | output | 1 | Software claim refused by the microcontroller lock |
| eng_go | output | 1 | Gated start pulse to the engine |
| eng_abort | output | 1 | Pulse when a running software batch is cut by hardware |
| eng_soft_rst | output | 1 | Engine soft-reset pulse on release from software ownership |
| stat_rst | output | 1 | Status-reset pulse on any software release |
| go_reject | output | 1 | Software GO refused |

## Verification
A corrupted state register shows up in the owner code and grant vector in the very next cycle, because both are decoded straight from the state. A lost or stuck pending-rerun flag is hidden until hardware hands the engine back. It then shows as a missing or extra engine GO in that one hand-back cycle, so the bench samples exactly there, after a preemption and after a parked GO. A wrong release decode shows as a soft-reset pulse in a cycle where the owner code was not software, one cycle after the release strobe.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SW_HOLD,
        ST_SW_RUN,
        ST_HW_HOLD,
        ST_MCU_LOCK
    } arb_state_e;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_SW   = 2'd1,
        OWN_HW   = 2'd2,
        OWN_MCU  = 2'd3
    } owner_e;

    localparam int AGENTS  = 3;
    // picker index order: lower index wins
    localparam int IDX_MCU = 0;
    localparam int IDX_HW  = 1;
    localparam int IDX_SW  = 2;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pick
            assign gnt[i]    = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate
endmodule

// File: rtl/i2c_arb_fsm.sv
module i2c_arb_fsm
    import i2c_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_claim,
    input  logic              sw_free,
    input  logic              sw_go,
    input  logic              hw_req,
    input  logic              hw_go,
    input  logic              mcu_req,
    input  logic              mcu_go,
    input  logic              hw_prio_high,
    input  logic              no_queue_go,
    input  logic              eng_done,
    input  logic [AGENTS-1:0] pick,
    output logic [1:0]        owner,
    output logic [2:0]        grant,
    output logic              sw_denied,
    output logic              eng_go,
    output logic              eng_abort,
    output logic              eng_soft_rst,
    output logic              stat_rst,
    output logic              go_reject
);
    arb_state_e state_q, state_d;
    logic       rerun_q, rerun_d;
    logic       go_d, abort_d, srst_d, strst_d, rej_d;
    logic       let_go;
    logic       preempt;

    function automatic arb_state_e pick_state(input logic [AGENTS-1:0] g, input logic p);
        if (g[IDX_MCU])     return ST_MCU_LOCK;
        else if (g[IDX_HW]) return ST_HW_HOLD;
        else if (g[IDX_SW]) return p ? ST_SW_RUN : ST_SW_HOLD;
        else                return ST_IDLE;
    endfunction

    assign let_go  = sw_free & ~sw_claim;
    assign preempt = hw_req & hw_prio_high;

    // next state and strobe decisions
    always_comb begin
        state_d = state_q;
        rerun_d = rerun_q;
        go_d    = 1'b0;
        abort_d = 1'b0;
        srst_d  = 1'b0;
        strst_d = 1'b0;
        rej_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (let_go) strst_d = 1'b1;
                if (sw_go)  rej_d   = 1'b1;
                state_d = pick_state(pick, rerun_q);
                if (state_d == ST_SW_RUN) begin
                    go_d    = 1'b1;
                    rerun_d = 1'b0;
                end
            end
            ST_SW_HOLD: begin
                if (let_go) begin
                    srst_d  = 1'b1;
                    strst_d = 1'b1;
                    state_d = ST_IDLE;
                end else if (preempt) begin
                    rerun_d = sw_go & sw_claim;
                    state_d = ST_HW_HOLD;
                end else if (sw_go && sw_claim) begin
                    go_d    = 1'b1;
                    state_d = ST_SW_RUN;
                end else if (sw_go) begin
                    rej_d = 1'b1;
                end
            end
            ST_SW_RUN: begin
                if (sw_go) rej_d = 1'b1;
                if (let_go) begin
                    srst_d  = 1'b1;
                    strst_d = 1'b1;
                    state_d = ST_IDLE;
                end else if (eng_done) begin
                    state_d = ST_SW_HOLD;
                end else if (preempt) begin
                    abort_d = 1'b1;
                    rerun_d = 1'b1;
                    state_d = ST_HW_HOLD;
                end
            end
            ST_HW_HOLD: begin
                if (let_go) begin
                    strst_d = 1'b1;
                    rerun_d = 1'b0;
                end else if (sw_go) begin
                    if (sw_claim && !no_queue_go) rerun_d = 1'b1;
                    else                          rej_d   = 1'b1;
                end
                if (hw_go && hw_req) go_d = 1'b1;
                if (!hw_req) begin
                    state_d = pick_state(pick, rerun_d);
                    if (state_d == ST_SW_RUN) begin
                        go_d    = 1'b1;
                        rerun_d = 1'b0;
                    end
                end
            end
            ST_MCU_LOCK: begin
                if (let_go) begin
                    strst_d = 1'b1;
                    rerun_d = 1'b0;
                end
                if (sw_go) rej_d = 1'b1;
                if (mcu_go && mcu_req) go_d = 1'b1;
                if (!mcu_req) begin
                    state_d = pick_state(pick, rerun_d);
                    if (state_d == ST_SW_RUN) begin
                        go_d    = 1'b1;
                        rerun_d = 1'b0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!sw_claim) rerun_d = 1'b0;
    end

    // state register and registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            rerun_q      <= 1'b0;
            eng_go       <= 1'b0;
            eng_abort    <= 1'b0;
            eng_soft_rst <= 1'b0;
            stat_rst     <= 1'b0;
            go_reject    <= 1'b0;
        end else begin
            state_q      <= state_d;
            rerun_q      <= rerun_d;
            eng_go       <= go_d;
            eng_abort    <= abort_d;
            eng_soft_rst <= srst_d;
            stat_rst     <= strst_d;
            go_reject    <= rej_d;
        end
    end

    // owner decode
    always_comb begin
        owner = OWN_NONE;
        grant = 3'b000;
        unique case (state_q)
            ST_IDLE:     begin owner = OWN_NONE; grant = 3'b000; end
            ST_SW_HOLD,
            ST_SW_RUN:   begin owner = OWN_SW;   grant = 3'b001; end
            ST_HW_HOLD:  begin owner = OWN_HW;   grant = 3'b010; end
            ST_MCU_LOCK: begin owner = OWN_MCU;  grant = 3'b100; end
            default:     begin owner = OWN_NONE; grant = 3'b000; end
        endcase
        sw_denied = (state_q == ST_MCU_LOCK) && sw_claim;
    end
endmodule

// File: rtl/i2c_owner_arb.sv
module i2c_owner_arb
    import i2c_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_claim,
    input  logic       sw_free,
    input  logic       sw_go,
    input  logic       hw_req,
    input  logic       hw_go,
    input  logic       mcu_req,
    input  logic       mcu_go,
    input  logic       hw_prio_high,
    input  logic       no_queue_go,
    input  logic       eng_done,
    output logic [1:0] owner,
    output logic [2:0] grant,
    output logic       sw_denied,
    output logic       eng_go,
    output logic       eng_abort,
    output logic       eng_soft_rst,
    output logic       stat_rst,
    output logic       go_reject
);
    logic [AGENTS-1:0] req_vec;
    logic [AGENTS-1:0] pick_vec;

    always_comb begin
        req_vec          = '0;
        req_vec[IDX_MCU] = mcu_req;
        req_vec[IDX_HW]  = hw_req;
        req_vec[IDX_SW]  = sw_claim;
    end

    arb_prio_pick #(.N(AGENTS)) u_pick (
        .req (req_vec),
        .gnt (pick_vec)
    );

    i2c_arb_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_claim     (sw_claim),
        .sw_free      (sw_free),
        .sw_go        (sw_go),
        .hw_req       (hw_req),
        .hw_go        (hw_go),
        .mcu_req      (mcu_req),
        .mcu_go       (mcu_go),
        .hw_prio_high (hw_prio_high),
        .no_queue_go  (no_queue_go),
        .eng_done     (eng_done),
        .pick         (pick_vec),
        .owner        (owner),
        .grant        (grant),
        .sw_denied    (sw_denied),
        .eng_go       (eng_go),
        .eng_abort    (eng_abort),
        .eng_soft_rst (eng_soft_rst),
        .stat_rst     (stat_rst),
        .go_reject    (go_reject)
    );
endmodule

// File: rtl/i2c_owner_arb_chk.sv
module i2c_owner_arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_go,
    input logic       hw_prio_high,
    input logic       mcu_req,
    input logic [1:0] owner,
    input logic [2:0] grant,
    input logic       eng_go,
    input logic       eng_abort,
    input logic       eng_soft_rst,
    input logic       stat_rst,
    input logic       go_reject
);
    p_onehot_grant_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_soft_only_sw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_soft_rst) |-> ($past(owner) == 2'd1) && stat_rst);

    p_mcu_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'd3 && mcu_req) |=> (owner == 2'd3));

    p_mcu_rejects_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'd3 && sw_go) |=> go_reject && !grant[0]);

    p_abort_to_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_abort) |-> (owner == 2'd2) && ($past(owner) == 2'd1) && $past(hw_prio_high));

    p_go_has_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_go |-> (grant != 3'b000));

    p_reject_no_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go_reject && owner != 2'd1) |-> !eng_go || (owner == 2'd2) || (owner == 2'd3));
endmodule

bind i2c_owner_arb i2c_owner_arb_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_go        (sw_go),
    .hw_prio_high (hw_prio_high),
    .mcu_req      (mcu_req),
    .owner        (owner),
    .grant        (grant),
    .eng_go       (eng_go),
    .eng_abort    (eng_abort),
    .eng_soft_rst (eng_soft_rst),
    .stat_rst     (stat_rst),
    .go_reject    (go_reject)
);

// File: tb/i2c_owner_arb_bench.sv
`timescale 1ns/1ps
module i2c_owner_arb_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_claim = 0, sw_free = 0, sw_go = 0;
    logic hw_req = 0, hw_go = 0, mcu_req = 0, mcu_go = 0;
    logic hw_prio_high = 1, no_queue_go = 0, eng_done = 0;
    logic [1:0] owner;
    logic [2:0] grant;
    logic sw_denied, eng_go, eng_abort, eng_soft_rst, stat_rst, go_reject;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_owner_arb u_i2c_owner_arb (
        .clk(clk), .rst_n(rst_n),
        .sw_claim(sw_claim), .sw_free(sw_free), .sw_go(sw_go),
        .hw_req(hw_req), .hw_go(hw_go), .mcu_req(mcu_req), .mcu_go(mcu_go),
        .hw_prio_high(hw_prio_high), .no_queue_go(no_queue_go), .eng_done(eng_done),
        .owner(owner), .grant(grant), .sw_denied(sw_denied), .eng_go(eng_go),
        .eng_abort(eng_abort), .eng_soft_rst(eng_soft_rst), .stat_rst(stat_rst),
        .go_reject(go_reject)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sw_release();
        sw_claim = 0; sw_free = 1;
        tick();
        sw_free = 0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 owner", owner, 0);
        chk("R1 grant", grant, 0);
        chk("R1 strobes", {eng_go, eng_abort, eng_soft_rst, stat_rst, go_reject}, 0);
    endtask

    task automatic t_priority();
        mcu_req = 1; hw_req = 1; sw_claim = 1;
        tick();
        chk("R2 mcu first", owner, 3);
        chk("R2 mcu grant", grant, 4);
        chk("R5 deny", sw_denied, 1);
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R5 reject", go_reject, 1);
        chk("R5 no go", eng_go, 0);
        chk("R5 still mcu", owner, 3);
        chk("R13 onehot", $countones(grant), 1);
        mcu_req = 0;
        tick();
        chk("R2 hw before sw", owner, 2);
        chk("R2 hw grant", grant, 2);
        hw_req = 0;
        tick();
        chk("R3 sw owner", owner, 1);
        chk("R3 sw grant", grant, 1);
        sw_claim = 0; sw_free = 1;
        tick();
        sw_free = 0;
        chk("R3 soft reset", eng_soft_rst, 1);
        chk("R3 status reset", stat_rst, 1);
        chk("R3 idle", owner, 0);
        tick();
        chk("R3 soft reset one cycle", eng_soft_rst, 0);
    endtask

    task automatic t_sw_run();
        sw_claim = 1;
        tick();
        chk("R3 acquire", owner, 1);
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R6 go", eng_go, 1);
        tick();
        chk("R6 go one cycle", eng_go, 0);
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R6 reject while running", go_reject, 1);
        chk("R6 no go while running", eng_go, 0);
        eng_done = 1;
        tick();
        eng_done = 0;
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R6 go after done", eng_go, 1);
        eng_done = 1;
        tick();
        eng_done = 0;
        sw_release();
    endtask

    task automatic t_preempt_restart();
        sw_claim = 1;
        tick();
        sw_go = 1;
        tick();
        sw_go = 0;
        hw_req = 1;
        tick();
        chk("R7 abort", eng_abort, 1);
        chk("R7 hw owner", owner, 2);
        hw_go = 1;
        tick();
        hw_go = 0;
        chk("R12 hw go passes", eng_go, 1);
        hw_req = 0;
        tick();
        chk("R8 back to sw", owner, 1);
        chk("R8 restart go", eng_go, 1);
        eng_done = 1;
        tick();
        eng_done = 0;
        sw_release();
    endtask

    task automatic t_release_not_sw();
        sw_claim = 1;
        tick();
        hw_req = 1;
        tick();
        chk("R4 preempt idle sw", owner, 2);
        chk("R4 no abort when idle", eng_abort, 0);
        sw_claim = 0; sw_free = 1;
        tick();
        sw_free = 0;
        chk("R4 status reset", stat_rst, 1);
        chk("R4 no soft reset", eng_soft_rst, 0);
        chk("R4 owner kept", owner, 2);
        hw_req = 0;
        tick();
        chk("R4 idle after hw", owner, 0);
    endtask

    task automatic t_low_prio();
        hw_prio_high = 0;
        sw_claim = 1;
        tick();
        sw_go = 1;
        tick();
        sw_go = 0;
        hw_req = 1;
        tick(); tick(); tick();
        chk("R9 no preempt", owner, 1);
        chk("R9 no abort", eng_abort, 0);
        eng_done = 1;
        tick();
        eng_done = 0;
        sw_claim = 0; sw_free = 1;
        tick();
        sw_free = 0;
        chk("R9 idle cycle", owner, 0);
        tick();
        chk("R9 hw after release", owner, 2);
        hw_req = 0;
        tick();
        hw_prio_high = 1;
    endtask

    task automatic t_queue();
        hw_req = 1;
        tick();
        sw_claim = 1;
        tick();
        chk("R10 hw keeps", owner, 2);
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R10 parked not rejected", go_reject, 0);
        chk("R10 no go yet", eng_go, 0);
        hw_req = 0;
        tick();
        chk("R10 sw owner", owner, 1);
        chk("R10 queued go", eng_go, 1);
        eng_done = 1;
        tick();
        eng_done = 0;
        sw_release();
    endtask

    task automatic t_noqueue();
        no_queue_go = 1;
        hw_req = 1;
        tick();
        sw_claim = 1;
        sw_go = 1;
        tick();
        sw_go = 0;
        chk("R11 reject", go_reject, 1);
        hw_req = 0;
        tick();
        chk("R11 sw owner", owner, 1);
        chk("R11 no go", eng_go, 0);
        sw_release();
        no_queue_go = 0;
    endtask

    task automatic t_gate();
        hw_go = 1; mcu_go = 1;
        tick();
        chk("R12 no owner no go", eng_go, 0);
        sw_claim = 1;
        tick();
        tick();
        chk("R12 sw owner blocks others", eng_go, 0);
        hw_go = 0; mcu_go = 0;
        sw_release();
        mcu_req = 1;
        tick();
        chk("R12 mcu owner", owner, 3);
        hw_go = 1;
        tick();
        hw_go = 0;
        chk("R12 hw go blocked", eng_go, 0);
        mcu_go = 1;
        tick();
        mcu_go = 0;
        chk("R12 mcu go passes", eng_go, 1);
        mcu_req = 0;
        tick();
        chk("R13 idle grant", grant, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_priority();
        t_sw_run();
        t_preempt_restart();
        t_release_not_sw();
        t_low_prio();
        t_queue();
        t_noqueue();
        t_gate();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule